// File: doc/BRIEF.md
# Multi-Mode Input Capture Timer

This block is a free-standing up-counting timer that time-stamps edges on an external, asynchronous input pin. The pin is brought into the clock domain through a short synchronizer. A programmable edge selector then decides which transition counts as an event. On each accepted event the running count is copied into a capture register. Three behaviours can be selected. In free capture the counter never stops and the copy is only a record. In restart capture, either an input event or a match against the reload value sends the counter back to one. In gated capture, the counter waits at one until the first input event arrives, and from then on it behaves like restart capture.

Software sets the block up through a small word-wide register port. This port holds the reload value, the operating behaviour, the edge polarity, the choice of interrupt sources and an output enable. The same port returns the capture register and the live count. The block drives one interrupt pulse, and it keeps a source flag that says whether the latest interrupt came from a capture or from a reload match. Every reload match toggles a timer output pin. The starting level of that pin follows the polarity bit.

Top module: `cap_timer`

## Requirements
- R1: After reset the count, the capture register, the reload value, the control word, the source flag, the interrupt and the timer output are all zero.
- R2: With polarity 0 (control bit 3) a rising pin edge is the event, and with polarity 1 a falling edge is. The opposite edge is ignored. An edge on the pin half a cycle after clock edge k is captured at clock edge k+3, and the value captured is the count held after clock edge k+2.
- R3: Writing the control word (address 1) with enable (bit 0) set while the timer is disabled loads the count with 1. In free mode (mode field bits 2:1 = 0) the count then rises by one per clock, wraps from FFFFh to 0000h, and is not disturbed by a capture.
- R4: In free mode a count equal to the reload value (address 0) is a reload event, and counting continues past it.
- R5: In restart mode (mode 1) a capture event or a reload event sets the count to 1 on the same clock edge.
- R6: In gated mode (mode 2) the count stays at 1 until the first selected edge. That edge only starts counting, with no capture. Every later selected edge captures and restarts as in R5.
- R7: The interrupt-source field (bits 5:4) means: 1 = captures only, 2 = reload events only, 0 or 3 = both.
- R8: An interrupt from a capture sets the source flag (read at control bit 7), and an interrupt from a reload event clears it. An unselected event leaves the flag unchanged.
- R9: Each interrupting event drives the interrupt high for exactly the one cycle after the edge at which the event is taken.
- R10: Enabling the timer sets the output level to the polarity bit, and every reload event inverts it. The pin shows that level only while the output enable (bit 6) is set and is low otherwise.
- R11: When a capture and a reload match fall on the same cycle, only the capture takes effect: no output toggle, and the flag is set.
- R12: A control write whose mode field differs from the current mode stores enable as 0. While the timer is disabled the count is frozen and pin edges are ignored, so the capture register holds its value.
- R13: Reads are registered. The value for rd_addr appears one clock later: 0 = reload, 1 = control word with the flag at bit 7, 2 = capture, 3 = count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Registered read data |
| tmr_in | input | 1 | Asynchronous timer input pin |
| tmr_out | output | 1 | Timer output pin |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
Any fault in the count state machine shows up within one period at the ports. A counter that is not sent back to one, or that is restarted when it should not be, gives a wrong capture value and shifts the interrupt and the output toggles away from the cycles the reload value predicts. A fault in the event arbitration shows on the first coincident event: a spurious output toggle, or a source flag cleared in the read that follows. A stale gate or enable state shows up as a count that moves while it should be frozen, or stays at one while it should run, and two reads a few cycles apart reveal it.

// File: rtl/cap_tmr_pkg.sv
package cap_tmr_pkg;

  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] ADDR_RELOAD = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_CTRL   = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_CAPT   = 2'd2;
  localparam logic [REG_AW-1:0] ADDR_COUNT  = 2'd3;

  typedef enum logic [1:0] {
    MODE_FREE    = 2'd0,
    MODE_RESTART = 2'd1,
    MODE_GATED   = 2'd2,
    MODE_SPARE   = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic       oe;
    logic [1:0] irq_sel;
    logic       pol;
    tmr_mode_e  mode;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/cap_tmr_sync.sv
module cap_tmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic pol_i,
  output logic edge_o
);

  logic [STAGES-1:0] chain;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain[STAGES-1];
  end

  always_comb begin
    if (pol_i) edge_o = prev_q & ~chain[STAGES-1];
    else       edge_o = chain[STAGES-1] & ~prev_q;
  end

endmodule

// File: rtl/cap_tmr_regs.sv
module cap_tmr_regs
  import cap_tmr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  input  logic [DW-1:0]     cap_i,
  input  logic [DW-1:0]     cnt_i,
  input  logic              flag_i,
  output ctrl_t             ctrl_o,
  output logic [DW-1:0]     reload_o,
  output logic              start_o,
  output logic              start_pol_o,
  output logic [DW-1:0]     rd_data_o
);

  ctrl_t ctrl_q;
  ctrl_t ctrl_wr;
  logic  do_ctrl;
  logic  do_reload;

  assign do_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
  assign do_reload = wr_en && (wr_addr == ADDR_RELOAD);

  always_comb begin
    ctrl_wr = ctrl_t'(wr_data[CTRL_W-1:0]);
    if (ctrl_wr.mode != ctrl_q.mode) ctrl_wr.en = 1'b0;
  end

  assign start_o     = do_ctrl && ctrl_wr.en && !ctrl_q.en;
  assign start_pol_o = ctrl_wr.pol;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_o <= '0;
    end else begin
      if (do_ctrl)   ctrl_q   <= ctrl_wr;
      if (do_reload) reload_o <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else begin
      unique case (rd_addr)
        ADDR_RELOAD: rd_data_o <= reload_o;
        ADDR_CTRL:   rd_data_o <= DW'({flag_i, ctrl_q});
        ADDR_CAPT:   rd_data_o <= cap_i;
        default:     rd_data_o <= cnt_i;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/cap_tmr_core.sv
module cap_tmr_core
  import cap_tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrl_t         ctrl_i,
  input  logic [CW-1:0] reload_i,
  input  logic          start_i,
  input  logic          start_pol_i,
  input  logic          edge_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cap_o,
  output logic          flag_o,
  output logic          irq_o,
  output logic          lvl_o,
  output logic          run_o
);

  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic gated;
  logic restart_mode;
  logic live;
  logic arm_evt;
  logic cap_evt;
  logic rld_evt;
  logic cap_irq_en;
  logic rld_irq_en;
  logic [CW-1:0] cnt_inc;

  assign gated        = (ctrl_i.mode == MODE_GATED);
  assign restart_mode = (ctrl_i.mode == MODE_RESTART) || gated;
  assign live         = ctrl_i.en && (!gated || run_o);
  assign arm_evt      = ctrl_i.en && gated && !run_o && edge_i;
  assign cap_evt      = live && edge_i;
  assign rld_evt      = live && (cnt_o == reload_i) && !cap_evt;
  assign cap_irq_en   = (ctrl_i.irq_sel != 2'd2);
  assign rld_irq_en   = (ctrl_i.irq_sel != 2'd1);
  assign cnt_inc      = cnt_o + CNT_ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      cap_o  <= '0;
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
      lvl_o  <= 1'b0;
      run_o  <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (start_i) begin
        cnt_o <= CNT_ONE;
        run_o <= 1'b0;
        lvl_o <= start_pol_i;
      end else if (arm_evt) begin
        cnt_o <= CNT_ONE;
        run_o <= 1'b1;
      end else if (cap_evt) begin
        cap_o <= cnt_o;
        cnt_o <= restart_mode ? CNT_ONE : cnt_inc;
        if (cap_irq_en) begin
          irq_o  <= 1'b1;
          flag_o <= 1'b1;
        end
      end else if (rld_evt) begin
        cnt_o <= restart_mode ? CNT_ONE : cnt_inc;
        lvl_o <= ~lvl_o;
        if (rld_irq_en) begin
          irq_o  <= 1'b1;
          flag_o <= 1'b0;
        end
      end else if (live) begin
        cnt_o <= cnt_inc;
      end
    end
  end

endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_tmr_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [CW-1:0]     rd_data,
  input  logic              tmr_in,
  output logic              tmr_out,
  output logic              irq
);

  ctrl_t         ctrl_q;
  logic [CW-1:0] reload_q;
  logic          start_p;
  logic          start_pol;
  logic          pin_edge;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cap_q;
  logic          flag_q;
  logic          lvl_q;
  logic          run_q;

  cap_tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (tmr_in),
    .pol_i  (ctrl_q.pol),
    .edge_o (pin_edge)
  );

  cap_tmr_regs #(.DW(CW)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .cap_i       (cap_q),
    .cnt_i       (cnt_q),
    .flag_i      (flag_q),
    .ctrl_o      (ctrl_q),
    .reload_o    (reload_q),
    .start_o     (start_p),
    .start_pol_o (start_pol),
    .rd_data_o   (rd_data)
  );

  cap_tmr_core #(.CW(CW)) u_core (
    .clk         (clk),
    .rst         (rst),
    .ctrl_i      (ctrl_q),
    .reload_i    (reload_q),
    .start_i     (start_p),
    .start_pol_i (start_pol),
    .edge_i      (pin_edge),
    .cnt_o       (cnt_q),
    .cap_o       (cap_q),
    .flag_o      (flag_q),
    .irq_o       (irq),
    .lvl_o       (lvl_q),
    .run_o       (run_q)
  );

  assign tmr_out = lvl_q & ctrl_q.oe;

endmodule

// File: rtl/cap_tmr_check.sv
module cap_tmr_check
  import cap_tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input ctrl_t         ctrl,
  input logic          start,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cap,
  input logic          flag,
  input logic          irq,
  input logic          lvl,
  input logic          running
);

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.en && !start) |=> $stable(cnt)); // R12

  AST_CAPT_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl.en) && ($past(ctrl.mode) == MODE_RESTART || $past(ctrl.mode) == MODE_GATED)
     && cap != $past(cap)) |-> cnt == CW'(1)); // R5

  AST_GATE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (ctrl.en && ctrl.mode == MODE_GATED && !running) |-> cnt == CW'(1)); // R6

  AST_FLAG_SET_IRQ: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> irq); // R8

  AST_FLAG_CLR_IRQ: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> irq); // R8

  AST_TOGGLE_AT_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (ctrl.en && $past(ctrl.en) && ($past(ctrl.mode) == MODE_RESTART || $past(ctrl.mode) == MODE_GATED)
     && lvl != $past(lvl)) |-> cnt == CW'(1)); // R10

endmodule

bind cap_timer cap_tmr_check #(.CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ctrl    (ctrl_q),
  .start   (start_p),
  .cnt     (cnt_q),
  .cap     (cap_q),
  .flag    (flag_q),
  .irq     (irq),
  .lvl     (lvl_q),
  .running (run_q)
);

// File: tb/sim_cap_timer.sv
`timescale 1ns/1ps
module sim_cap_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        tmr_in = 1'b0;
  logic        tmr_out;
  logic        irq;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  cap_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tmr_in(tmr_in), .tmr_out(tmr_out), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        pol;
    logic [15:0] rld;
    logic [7:0]  d1;
    logic [7:0]  d2;
    logic [15:0] expv;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{mode: 2'd0, pol: 1'b0, rld: 16'd5,   d1: 8'd10, d2: 8'd0,  expv: 16'd13},
    '{mode: 2'd0, pol: 1'b1, rld: 16'd100, d1: 8'd3,  d2: 8'd0,  expv: 16'd6},
    '{mode: 2'd1, pol: 1'b0, rld: 16'd5,   d1: 8'd10, d2: 8'd0,  expv: 16'd3},
    '{mode: 2'd1, pol: 1'b1, rld: 16'd7,   d1: 8'd20, d2: 8'd0,  expv: 16'd2},
    '{mode: 2'd2, pol: 1'b0, rld: 16'd50,  d1: 8'd6,  d2: 8'd9,  expv: 16'd9},
    '{mode: 2'd2, pol: 1'b1, rld: 16'd4,   d1: 8'd2,  d2: 8'd11, expv: 16'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  function automatic logic [15:0] cword(input logic en, input logic [1:0] mode,
                                        input logic pol, input logic [1:0] sel, input logic oe);
    return {9'd0, oe, sel, pol, mode, en};
  endfunction

  task automatic setup(input logic [1:0] mode, input logic pol, input logic [1:0] sel,
                       input logic oe, input logic [15:0] rld);
    tmr_in = pol;
    wr(2'd1, cword(1'b0, mode, pol, sel, oe));
    wr(2'd0, rld);
    repeat (4) @(negedge clk);
    wr(2'd1, cword(1'b1, mode, pol, sel, oe));
  endtask

  task automatic pulse(input logic pol);
    tmr_in = ~pol;
    repeat (2) @(negedge clk);
    tmr_in = pol;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] v2;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 tmr_out", tmr_out, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 register", v, 0);
    end

    // R13 reload readback
    wr(2'd0, 16'h1234);
    rd(2'd0, v);
    chk("R13 reload readback", v, 16'h1234);

    // table of capture scenarios: R2 R3 R5 R6
    for (int i = 0; i < NV; i++) begin
      vec_t t = VECS[i];
      setup(t.mode, t.pol, 2'd1, 1'b0, t.rld);
      repeat (int'(t.d1)) @(negedge clk);
      pulse(t.pol);
      if (t.mode == 2'd2) begin
        repeat (int'(t.d2) - 2) @(negedge clk);
        pulse(t.pol);
      end
      repeat (4) @(negedge clk);
      wr(2'd1, cword(1'b0, t.mode, t.pol, 2'd1, 1'b0));
      rd(2'd2, v);
      if (t.mode == 2'd0)      chk("R2 R3 free capture", v, t.expv);
      else if (t.mode == 2'd1) chk("R2 R5 restart capture", v, t.expv);
      else                     chk("R2 R6 gated capture", v, t.expv);
      rd(2'd1, v);
      chk("R8 flag after capture", v[7], 1);
    end

    // R10 R9 R5 output toggling and pulses in restart mode, both polarities
    for (int p = 0; p < 2; p++) begin
      setup(2'd1, p[0], 2'd2, 1'b1, 16'd4);
      for (int j = 1; j <= 12; j++) begin
        @(negedge clk);
        chk("R9 irq pulse", irq, (j % 4 == 0));
        chk("R10 output level", tmr_out, p[0] ^ ((j / 4) % 2 == 1));
      end
      rd(2'd1, v);
      chk("R8 flag cleared by reload", v[7], 0);
    end

    // R4 free mode reload interrupt, output disabled
    setup(2'd0, 1'b0, 2'd0, 1'b0, 16'd3);
    for (int j = 1; j <= 10; j++) begin
      @(negedge clk);
      chk("R4 free reload irq", irq, (j == 3));
      chk("R10 output gated off", tmr_out, 0);
    end

    // R7 capture-only selection suppresses reload interrupts
    setup(2'd0, 1'b0, 2'd1, 1'b0, 16'd3);
    v2 = 0;
    for (int j = 1; j <= 10; j++) begin
      @(negedge clk);
      if (irq) v2 = v2 + 1;
    end
    chk("R7 no reload irq when captures only", v2, 0);

    // R7 reload-only selection: capture gives no interrupt but is still stored
    setup(2'd0, 1'b0, 2'd2, 1'b0, 16'd1000);
    repeat (4) @(negedge clk);
    tmr_in = 1'b1;
    v2 = 0;
    for (int j = 1; j <= 6; j++) begin
      @(negedge clk);
      if (irq) v2 = v2 + 1;
    end
    tmr_in = 1'b0;
    chk("R7 no capture irq when reloads only", v2, 0);
    rd(2'd2, v);
    chk("R7 capture stored without irq", v, 16'd7);

    // R3 wrap from FFFF to 0000
    setup(2'd0, 1'b0, 2'd1, 1'b0, 16'h0010);
    repeat (65540) @(negedge clk);
    wr(2'd1, cword(1'b0, 2'd0, 1'b0, 2'd1, 1'b0));
    rd(2'd3, v);
    chk("R3 wrapped count", v, 16'd7);

    // R11 coincident capture and reload match
    setup(2'd1, 1'b0, 2'd0, 1'b1, 16'd6);
    repeat (3) @(negedge clk);
    pulse(1'b0);
    @(negedge clk);
    chk("R11 irq on coincident event", irq, 1);
    chk("R11 no toggle", tmr_out, 0);
    rd(2'd1, v);
    chk("R11 flag marks capture", v[7], 1);
    rd(2'd2, v);
    chk("R11 captured value", v, 16'd6);

    // R12 mode change clears enable, count frozen, edges ignored
    setup(2'd0, 1'b0, 2'd0, 1'b0, 16'hFFF0);
    repeat (5) @(negedge clk);
    wr(2'd1, cword(1'b1, 2'd1, 1'b0, 2'd0, 1'b0));
    rd(2'd1, v);
    chk("R12 enable cleared", v[0], 0);
    rd(2'd3, v);
    pulse(1'b0);
    repeat (5) @(negedge clk);
    rd(2'd3, v2);
    chk("R12 count frozen", v2, v);
    rd(2'd2, v);
    chk("R12 capture held", v, 16'd6);

    // R6 gated mode idles at one
    setup(2'd2, 1'b0, 2'd0, 1'b0, 16'd50);
    repeat (20) @(negedge clk);
    rd(2'd3, v);
    chk("R6 gated idle count", v, 16'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule